// File: doc/BRIEF.md
# Interleaved Chroma 4x4 Dequantize, Inverse Transform and Reconstruct

This block rebuilds one 4x4 tile of a single colour plane. The plane is stored byte-interleaved with a second plane, so the two planes alternate byte by byte. A job carries sixteen quantized coefficients, a scale table, a weight table, a signed quantizer shift and a DC value that is supplied separately. The block dequantizes the coefficients and always puts the supplied DC value in place of coefficient 0. It then runs a separable 4-point integer inverse transform and stores the rounded residual tile.

The tile is then written back one row at a time. For each row the block asks for the row that is already stored at the destination. It accepts one 8-byte prediction row and the returned 8-byte old row. It adds the residual to the even prediction bytes and clips the result. It then writes an 8-byte row in which the even bytes are the new pixels and the odd bytes, which belong to the other plane, are copied from the old row. Every channel uses a valid/ready handshake. The caller computes the DC value and chooses where the plane sits in memory.

Top module: `chroma_rec_top`

## Requirements
- R1: Coefficient i sits at job_coef[16i+15:16i], and likewise in job_scale and job_weight, with i = 4*row + column. The factor is the low 16 bits of scale*weight, read as a signed value. It is multiplied by the signed coefficient to give a 32-bit product.
- R2: When job_qshift (signed, 5 bits) is zero or positive, the product is shifted left with 32-bit wraparound. When it is negative, the product is shifted arithmetically right by its magnitude. Then 8 is added, the sum is shifted arithmetically right by 4, and the result is saturated to the range -32768..32767.
- R3: After dequantization, coefficient 0 is replaced by job_dc, whatever the coefficient, scale and weight in that position.
- R4: A 4-point butterfly is applied to each row first and then to each column, with 16-bit wraparound arithmetic. With inputs a0..a3: e0=a0+a2, e1=a0-a2, e2=(a1>>>1)-a3, e3=a1+(a3>>>1). The outputs are y0=e0+e3, y1=e1+e2, y2=e1-e2, y3=e0-e3.
- R5: Each transform output r is rounded to (r+32)>>>6. For column k it is added to prediction byte 2k (bits 16k+7:16k) and clipped to 0..255. The result goes to output byte 2k.
- R6: Output odd bytes 2k+1 equal the odd bytes of the old row returned for that row. The odd bytes of the prediction row have no effect.
- R7: For each row the block first issues an old-row request carrying the row index. out_valid stays low until that old row and the prediction row have both been accepted. Rows leave in order 0,1,2,3, and out_last is high only on row 3.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_row hold. old_req_valid and old_req_row hold until the request is accepted.
- R9: After reset, job_ready is 1 and both out_valid and old_req_valid are 0. job_ready is high only when no row is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Job accepted when high together with job_valid |
| job_coef | input | 256 | Sixteen signed 16-bit coefficients |
| job_scale | input | 256 | Sixteen 16-bit scale entries |
| job_weight | input | 256 | Sixteen 16-bit weight entries |
| job_qshift | input | 5 | Signed quantizer shift |
| job_dc | input | 16 | Signed DC value that replaces coefficient 0 |
| pred_valid | input | 1 | Prediction row offered |
| pred_ready | output | 1 | Prediction row accepted |
| pred_data | input | 64 | Interleaved prediction row, byte 0 in bits 7:0 |
| old_req_valid | output | 1 | Request for the stored row |
| old_req_ready | input | 1 | Request accepted |
| old_req_row | output | 2 | Index of the requested row |
| old_rsp_valid | input | 1 | Stored row returned |
| old_rsp_ready | output | 1 | Stored row accepted |
| old_rsp_data | input | 64 | Stored interleaved row |
| out_valid | output | 1 | Merged row offered |
| out_ready | input | 1 | Merged row accepted |
| out_data | output | 64 | Merged interleaved row |
| out_row | output | 2 | Index of the offered row |
| out_last | output | 1 | High on the last row of the tile |

## Verification
The assertions assume that old rows come back only after the block has asked for them, at most one per request, and that a stalled offer on any handshake is not withdrawn. The bench drives each channel on its own with random stalls. It returns an old row only after a request has been accepted, and it holds every valid until the matching ready has been seen. The random jobs keep the quantizer shift between -8 and 15 so that the signed shift port stays in range. Directed jobs push the dequantizer into saturation, the pixels into both clip limits, and coefficient 0 to its extreme values.

// File: rtl/chroma_rec_pkg.sv
package chroma_rec_pkg;
    localparam int COEF_W    = 16;
    localparam int PIX_W     = 8;
    localparam int BLK       = 4;
    localparam int NCOEF     = BLK * BLK;
    localparam int ROW_W     = 2 * BLK * PIX_W;
    localparam int QSH_W     = 5;
    localparam int DQ_SH     = 4;
    localparam int RES_SH    = 6;
    localparam int ROW_IDX_W = $clog2(BLK);
    localparam int BUS_W     = NCOEF * COEF_W;

    typedef logic signed [COEF_W-1:0] coef_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQ     = 2'd1,
        ST_COLLECT = 2'd2,
        ST_WRITE   = 2'd3
    } st_e;

    typedef struct packed {
        st_e                  st;
        logic [ROW_IDX_W-1:0] row;
        coef_t [NCOEF-1:0]    resid;
        logic [ROW_W-1:0]     pred;
        logic [ROW_W-1:0]     old;
        logic                 have_pred;
        logic                 have_old;
    } ctx_t;
endpackage

// File: rtl/chroma_rec_dequant.sv
module chroma_rec_dequant
    import chroma_rec_pkg::*;
(
    input  coef_t                    coef_i,
    input  logic [COEF_W-1:0]        scale_i,
    input  logic [COEF_W-1:0]        weight_i,
    input  logic signed [QSH_W-1:0]  qsh_i,
    output coef_t                    deq_o
);
    localparam int PW = 2 * COEF_W;
    localparam logic signed [PW:0] RND_ADD = (PW+1)'(1 << (DQ_SH - 1));
    localparam logic signed [PW:0] MAX_V   = (PW+1)'((1 << (COEF_W - 1)) - 1);
    localparam logic signed [PW:0] MIN_V   = -(PW+1)'(1 << (COEF_W - 1));

    coef_t                 factor;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  shifted;
    logic [QSH_W-1:0]      mag;
    logic signed [PW:0]    rnd;

    always_comb begin
        factor  = coef_t'(scale_i * weight_i);
        prod    = PW'(coef_i) * PW'(factor);
        mag     = qsh_i[QSH_W-1] ? QSH_W'(-qsh_i) : QSH_W'(qsh_i);
        shifted = qsh_i[QSH_W-1] ? (prod >>> mag) : (prod <<< mag);
        rnd     = ($signed({shifted[PW-1], shifted}) + RND_ADD) >>> DQ_SH;
        if (rnd > MAX_V)      deq_o = coef_t'(MAX_V[COEF_W-1:0]);
        else if (rnd < MIN_V) deq_o = coef_t'(MIN_V[COEF_W-1:0]);
        else                  deq_o = coef_t'(rnd[COEF_W-1:0]);
    end
endmodule

// File: rtl/chroma_rec_bfly4.sv
module chroma_rec_bfly4
    import chroma_rec_pkg::*;
(
    input  coef_t [BLK-1:0] a_i,
    output coef_t [BLK-1:0] y_o
);
    coef_t e0, e1, e2, e3;

    always_comb begin
        e0     = a_i[0] + a_i[2];
        e1     = a_i[0] - a_i[2];
        e2     = ($signed(a_i[1]) >>> 1) - a_i[3];
        e3     = a_i[1] + ($signed(a_i[3]) >>> 1);
        y_o[0] = e0 + e3;
        y_o[1] = e1 + e2;
        y_o[2] = e1 - e2;
        y_o[3] = e0 - e3;
    end
endmodule

// File: rtl/chroma_rec_top.sv
module chroma_rec_top
    import chroma_rec_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   job_valid,
    output logic                   job_ready,
    input  logic [BUS_W-1:0]       job_coef,
    input  logic [BUS_W-1:0]       job_scale,
    input  logic [BUS_W-1:0]       job_weight,
    input  logic signed [QSH_W-1:0] job_qshift,
    input  logic signed [COEF_W-1:0] job_dc,
    input  logic                   pred_valid,
    output logic                   pred_ready,
    input  logic [ROW_W-1:0]       pred_data,
    output logic                   old_req_valid,
    input  logic                   old_req_ready,
    output logic [ROW_IDX_W-1:0]   old_req_row,
    input  logic                   old_rsp_valid,
    output logic                   old_rsp_ready,
    input  logic [ROW_W-1:0]       old_rsp_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [ROW_W-1:0]       out_data,
    output logic [ROW_IDX_W-1:0]   out_row,
    output logic                   out_last
);
    localparam logic signed [COEF_W:0] RES_ADD = (COEF_W+1)'(1 << (RES_SH - 1));
    localparam logic [COEF_W-1:0]      PIX_MAX = COEF_W'((1 << PIX_W) - 1);
    localparam ctx_t CTX_RST = '0;

    coef_t [NCOEF-1:0] dq, dq_dc, hz, vt, res_d;
    ctx_t ctx_d, ctx_q;
    logic [ROW_W-1:0] merged;

    // dequantization, one unit per coefficient
    for (genvar i = 0; i < NCOEF; i++) begin : g_dq
        chroma_rec_dequant u_dq (
            .coef_i  (coef_t'(job_coef[i*COEF_W +: COEF_W])),
            .scale_i (job_scale[i*COEF_W +: COEF_W]),
            .weight_i(job_weight[i*COEF_W +: COEF_W]),
            .qsh_i   (job_qshift),
            .deq_o   (dq[i])
        );
    end

    // R3: the DC slot always takes the supplied value
    always_comb begin
        dq_dc    = dq;
        dq_dc[0] = job_dc;
    end

    // R4: row pass then column pass
    for (genvar r = 0; r < BLK; r++) begin : g_row
        chroma_rec_bfly4 u_h (.a_i(dq_dc[r*BLK +: BLK]), .y_o(hz[r*BLK +: BLK]));
    end

    for (genvar k = 0; k < BLK; k++) begin : g_col
        coef_t [BLK-1:0] col_in, col_out;
        for (genvar m = 0; m < BLK; m++) begin : g_pick
            assign col_in[m]      = hz[m*BLK + k];
            assign vt[m*BLK + k]  = col_out[m];
        end
        chroma_rec_bfly4 u_v (.a_i(col_in), .y_o(col_out));
    end

    // R5: residual rounding before storage
    always_comb begin
        logic signed [COEF_W:0] tmp;
        for (int i = 0; i < NCOEF; i++) begin
            tmp      = ($signed({vt[i][COEF_W-1], vt[i]}) + RES_ADD) >>> RES_SH;
            res_d[i] = coef_t'(tmp[COEF_W-1:0]);
        end
    end

    // R5/R6: merge current row into the stored interleaved row
    always_comb begin
        coef_t                r;
        logic [COEF_W:0]      s;
        merged = ctx_q.old;
        for (int k = 0; k < BLK; k++) begin
            r = ctx_q.resid[int'(ctx_q.row) * BLK + k];
            s = {r[COEF_W-1], r} + {{(COEF_W+1-PIX_W){1'b0}}, ctx_q.pred[2*k*PIX_W +: PIX_W]};
            if (s[COEF_W])                      merged[2*k*PIX_W +: PIX_W] = '0;
            else if (s[COEF_W-1:0] > PIX_MAX)   merged[2*k*PIX_W +: PIX_W] = '1;
            else                                merged[2*k*PIX_W +: PIX_W] = s[PIX_W-1:0];
        end
    end

    always_comb begin
        ctx_d         = ctx_q;
        job_ready     = (ctx_q.st == ST_IDLE);
        old_req_valid = (ctx_q.st == ST_REQ);
        old_req_row   = ctx_q.row;
        pred_ready    = ((ctx_q.st == ST_REQ) || (ctx_q.st == ST_COLLECT)) && !ctx_q.have_pred;
        old_rsp_ready = (ctx_q.st == ST_COLLECT) && !ctx_q.have_old;
        out_valid     = (ctx_q.st == ST_WRITE);
        out_data      = merged;
        out_row       = ctx_q.row;
        out_last      = (ctx_q.row == ROW_IDX_W'(BLK - 1));

        if (pred_valid && pred_ready) begin
            ctx_d.pred      = pred_data;
            ctx_d.have_pred = 1'b1;
        end
        if (old_rsp_valid && old_rsp_ready) begin
            ctx_d.old      = old_rsp_data;
            ctx_d.have_old = 1'b1;
        end

        unique case (ctx_q.st)
            ST_IDLE: if (job_valid) begin
                ctx_d.resid     = res_d;
                ctx_d.row       = '0;
                ctx_d.have_pred = 1'b0;
                ctx_d.have_old  = 1'b0;
                ctx_d.st        = ST_REQ;
            end
            ST_REQ: if (old_req_ready) ctx_d.st = ST_COLLECT;
            ST_COLLECT: if (ctx_d.have_pred && ctx_d.have_old) ctx_d.st = ST_WRITE;
            ST_WRITE: if (out_ready) begin
                ctx_d.have_pred = 1'b0;
                ctx_d.have_old  = 1'b0;
                if (out_last) ctx_d.st = ST_IDLE;
                else begin
                    ctx_d.row = ctx_q.row + 1'b1;
                    ctx_d.st  = ST_REQ;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= CTX_RST;
        else        ctx_q <= ctx_d;
    end
endmodule

// File: rtl/chroma_rec_chk.sv
module chroma_rec_chk
    import chroma_rec_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 job_ready,
    input logic                 old_req_valid,
    input logic                 old_req_ready,
    input logic [ROW_IDX_W-1:0] old_req_row,
    input logic                 old_rsp_valid,
    input logic                 old_rsp_ready,
    input logic [ROW_W-1:0]     old_rsp_data,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [ROW_W-1:0]     out_data,
    input logic [ROW_IDX_W-1:0] out_row,
    input logic                 out_last
);
    logic [ROW_IDX_W-1:0] exp_row_q;
    logic                 got_old_q;
    logic [ROW_W-1:0]     old_q;
    logic [ROW_W-1:0]     odd_mask;

    always_comb begin
        odd_mask = '0;
        for (int k = 0; k < BLK; k++) odd_mask[(2*k+1)*PIX_W +: PIX_W] = '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_row_q <= '0;
            got_old_q <= 1'b0;
            old_q     <= '0;
        end else begin
            if (old_rsp_valid && old_rsp_ready) begin
                got_old_q <= 1'b1;
                old_q     <= old_rsp_data;
            end
            if (out_valid && out_ready) begin
                got_old_q <= 1'b0;
                exp_row_q <= exp_row_q + 1'b1;
            end
        end
    end

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        job_ready |-> (!out_valid && !old_req_valid));
    assert_row_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_row == exp_row_q));
    assert_last_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (out_row == ROW_IDX_W'(BLK - 1))));
    assert_old_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> got_old_q);
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_row)));
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (old_req_valid && !old_req_ready) |=> (old_req_valid && $stable(old_req_row)));
    assert_odd_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & odd_mask) == (old_q & odd_mask)));
endmodule

bind chroma_rec_top chroma_rec_chk u_chk (.*);

// File: tb/chroma_rec_top_tb.sv
module chroma_rec_top_tb;
    import chroma_rec_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic job_valid = 0, pred_valid = 0, old_req_ready = 0, old_rsp_valid = 0, out_ready = 0;
    logic job_ready, pred_ready, old_req_valid, old_rsp_ready, out_valid, out_last;
    logic [BUS_W-1:0] job_coef = '0, job_scale = '0, job_weight = '0;
    logic signed [QSH_W-1:0] job_qshift = '0;
    logic signed [COEF_W-1:0] job_dc = '0;
    logic [ROW_W-1:0] pred_data = '0, old_rsp_data = '0, out_data;
    logic [ROW_IDX_W-1:0] old_req_row, out_row;

    int n_chk = 0, n_fail = 0;
    int gc[16], gs[16], gw[16], gqs, gdc;
    logic [63:0] gpd[4], god[4], gex[4];

    always #5 clk = ~clk;

    chroma_rec_top u_dut (.*);

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int deq(int c, int s, int w, int qs);
        longint sw, p, q;
        int p32;
        sw = (longint'(s) * w) & 64'hFFFF;          // R1
        if (sw >= 32768) sw -= 65536;
        p = longint'(c) * sw;
        if (qs >= 0) p32 = int'(p <<< qs);           // R2
        else         p32 = int'(p) >>> (-qs);
        q = (longint'(p32) + 8) >>> 4;
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return int'(q);
    endfunction

    function automatic void model();
        shortint m[16], t[16], v[16];
        shortint e0, e1, e2, e3;
        int res, pix;
        for (int i = 0; i < 16; i++) m[i] = shortint'(deq(gc[i], gs[i], gw[i], gqs));
        m[0] = shortint'(gdc);                        // R3
        for (int r = 0; r < 4; r++) begin             // R4 rows
            e0 = m[4*r] + m[4*r+2];  e1 = m[4*r] - m[4*r+2];
            e2 = (m[4*r+1] >>> 1) - m[4*r+3];  e3 = m[4*r+1] + (m[4*r+3] >>> 1);
            t[4*r] = e0 + e3; t[4*r+1] = e1 + e2; t[4*r+2] = e1 - e2; t[4*r+3] = e0 - e3;
        end
        for (int k = 0; k < 4; k++) begin             // R4 columns
            e0 = t[k] + t[8+k];  e1 = t[k] - t[8+k];
            e2 = (t[4+k] >>> 1) - t[12+k];  e3 = t[4+k] + (t[12+k] >>> 1);
            v[k] = e0 + e3; v[4+k] = e1 + e2; v[8+k] = e1 - e2; v[12+k] = e0 - e3;
        end
        for (int r = 0; r < 4; r++) begin
            gex[r] = god[r];                          // R6 odd bytes from old row
            for (int k = 0; k < 4; k++) begin         // R5
                res = (int'(v[4*r+k]) + 32) >>> 6;
                pix = res + int'(gpd[r][16*k +: 8]);
                if (pix < 0) pix = 0;
                if (pix > 255) pix = 255;
                gex[r][16*k +: 8] = 8'(pix);
            end
        end
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_row(int r);
        int d_req, d_rsp, d_pred, d_out;
        d_req = $urandom_range(0, 2); d_rsp = $urandom_range(0, 3);
        d_pred = $urandom_range(0, 4); d_out = $urandom_range(0, 2);
        fork
            begin
                while (!old_req_valid) tick();
                chk(old_req_row == 2'(r), "R7 request row", 64'(old_req_row), 64'(r));
                chk(!job_ready, "R9 busy", 64'(job_ready), 64'd0);
                repeat (d_req) tick();
                old_req_ready = 1; tick(); old_req_ready = 0;
                repeat (d_rsp) begin
                    chk(!out_valid, "R7 wait for old row", 64'(out_valid), 64'd0);
                    tick();
                end
                old_rsp_data = god[r]; old_rsp_valid = 1;
                while (!old_rsp_ready) tick();
                tick(); old_rsp_valid = 0;
            end
            begin
                repeat (d_pred) tick();
                pred_data = gpd[r]; pred_valid = 1;
                while (!pred_ready) tick();
                tick(); pred_valid = 0;
            end
        join
        while (!out_valid) tick();
        repeat (d_out) begin
            chk(out_data == gex[r], "R8 held data", out_data, gex[r]);
            tick();
        end
        chk(out_data == gex[r], "R5 R6 row data", out_data, gex[r]);
        chk(out_row == 2'(r), "R7 row index", 64'(out_row), 64'(r));
        chk(out_last == (r == 3), "R7 last flag", 64'(out_last), 64'(r == 3));
        out_ready = 1; tick(); out_ready = 0;
    endtask

    task automatic run_job();
        for (int i = 0; i < 16; i++) begin
            job_coef[16*i +: 16]   = 16'(gc[i]);
            job_scale[16*i +: 16]  = 16'(gs[i]);
            job_weight[16*i +: 16] = 16'(gw[i]);
        end
        job_qshift = 5'(gqs); job_dc = 16'(gdc);
        model();
        job_valid = 1;
        while (!job_ready) tick();
        tick(); job_valid = 0;
        for (int r = 0; r < 4; r++) do_row(r);
    endtask

    task automatic rand_rows();
        for (int r = 0; r < 4; r++) begin
            gpd[r] = {$urandom, $urandom};
            god[r] = {$urandom, $urandom};
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20250601));
        repeat (3) tick();
        rst_n = 1; tick();
        chk(job_ready == 1, "R9 reset job_ready", 64'(job_ready), 64'd1);
        chk(out_valid == 0, "R9 reset out_valid", 64'(out_valid), 64'd0);
        chk(old_req_valid == 0, "R9 reset old_req_valid", 64'(old_req_valid), 64'd0);

        // R3: only DC, coefficient 0 extreme and ignored
        for (int i = 0; i < 16; i++) begin gc[i] = 0; gs[i] = 16; gw[i] = 16; end
        gc[0] = 32767; gs[0] = 65535; gw[0] = 65535; gqs = 6; gdc = 100;
        rand_rows(); run_job();

        // R5: clip high then clip low
        gdc = 4000; for (int r = 0; r < 4; r++) gpd[r] = {8{8'hF0}};
        run_job();
        gdc = -4000; for (int r = 0; r < 4; r++) gpd[r] = {8{8'h10}};
        run_job();

        // R2: saturation, wraparound factor (R1), large left shift
        for (int i = 0; i < 16; i++) begin gc[i] = (i % 2) ? -32768 : 32767; gs[i] = 255; gw[i] = 255; end
        gqs = 15; gdc = 0; rand_rows(); run_job();
        gqs = -8; rand_rows(); run_job();
        for (int i = 0; i < 16; i++) begin gc[i] = 3 - i; gs[i] = 300 + i; gw[i] = 250; end
        gqs = 0; gdc = -7; rand_rows(); run_job();   // R1: scale*weight beyond 16 bits

        for (int j = 0; j < 40; j++) begin
            for (int i = 0; i < 16; i++) begin
                gc[i] = $urandom_range(0, 127) - 64;
                gs[i] = $urandom_range(0, 31);
                gw[i] = $urandom_range(0, 31);
            end
            if (j % 8 == 0) for (int i = 0; i < 16; i++) gc[i] = $urandom_range(0, 65535) - 32768;
            gqs = $urandom_range(0, 23) - 8;
            gdc = $urandom_range(0, 4095) - 2048;
            rand_rows(); run_job();
        end
        tick();
        chk(job_ready == 1, "R9 idle after jobs", 64'(job_ready), 64'd1);
        summary();
        $finish;
    end
endmodule